// File: doc/BRIEF.md
# Twelve-Sector Dwell Time Calculator

This block turns a reference voltage vector, given as an angle and a normalized length, into the three dwell times that a space-vector pattern generator needs for one switching period. It splits the voltage plane into twelve sectors of 30 degrees each. In every sector the reference is built from two active vectors that share the same common-mode level, plus the single zero vector. The zero vector only fills whatever time the two active vectors leave over.

A request carries the angle as an unsigned fraction of a full turn and the length as an unsigned fraction of the active-vector length. After a fixed number of clock cycles the block returns a one-cycle valid strobe. With it come the sector number (1 to 12), a flag that marks the upper half of the sector, and the first-active, second-active and zero dwell counts. These counts are expressed in clock cycles of one switching period. The default period is 10000 cycles, which gives 5 kHz at a 50 MHz count clock. Odd and even sectors use different dwell formulas. If the two active times together would exceed the period, both are scaled down in proportion and the zero time becomes 0.

Top module: `twelve_sector_dwell`

## Requirements
- R1: The sector output is floor(angle·12 / 2^ANG_W) + 1. It is chosen by comparing the angle against the eleven sector edges ceil(k·2^ANG_W/12).
- R2: Let r = (angle·12) mod 2^ANG_W be the position inside the sector. The upper-half flag is 1 exactly when r ≥ 2^(ANG_W−1), that is, when the in-sector angle θ = r·30°/2^ANG_W is at least 15°.
- R3: In odd sectors (1, 3, …, 11), with c = (2/√3)·(mag/2^MAG_W)·TS, the first time is c·sin(120°−θ) and the second time is c·sin(θ). Each is within TS/50 counts.
- R4: In even sectors (2, 4, …, 12), the first time is c·sin(θ+90°) and the second time is c·sin(30°−θ). Each is within TS/50 counts.
- R5: For every result, the zero time equals TS minus the two active times, so the three counts add up to exactly TS.
- R6: When the two active times would add up to more than TS, both are scaled by TS/(sum), the second time becomes TS minus the scaled first time, and the zero time is 0.
- R7: Each request accepted on a rising edge gives exactly one output valid cycle, four edges later. Back-to-back requests give back-to-back results in the same order.
- R8: While the output valid is low, every result output keeps its last value. This holds no matter how the request inputs change.
- R9: During reset the output valid is 0, the sector is 0, the flag is 0 and all three times are 0.
- R10: A zero magnitude gives both active times 0 and a zero time of exactly TS.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Count clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per switching period |
| req_angle | input | ANG_W | Reference angle as a fraction of a full turn |
| req_mag | input | MAG_W | Reference length as a fraction of the active-vector length |
| out_valid | output | 1 | One-cycle result strobe |
| out_sector | output | 4 | Sector number 1..12 |
| out_upper_half | output | 1 | In-sector angle is at least 15 degrees |
| out_t_first | output | CNT_W | First active vector dwell, in cycles |
| out_t_second | output | CNT_W | Second active vector dwell, in cycles |
| out_t_zero | output | CNT_W | Zero vector dwell, in cycles |

## Verification
Some properties are checked on every cycle: the four-edge latency, the exact period sum, the legal sector range, a zero time of 0 whenever the overflow clamp is taken, zero active times for a zero magnitude, and outputs that hold while the strobe is low. Other behaviour shows only in the bench's scenarios. These are whether the sector edges and the 15-degree split fall at the right angle codes, whether odd and even sectors use the right pair of sine arguments, and whether the proportional scaling keeps the ratio of the two active times. The bench checks them against dwell values it computes with real arithmetic.

// File: rtl/lcm_dwell_pkg.sv
package lcm_dwell_pkg;

  localparam int SECTORS = 12;
  // pi/2 in Q30 and 2/sqrt(3) in Q20
  localparam longint HALF_PI_Q30   = 64'sd1686629713;
  localparam longint INV_SIN60_Q20 = 64'sd1210791;

  typedef enum logic {SECT_ODD = 1'b0, SECT_EVEN = 1'b1} sect_kind_e;

  // sin(idx * 90deg / steps) in Q(frac), odd Taylor series to x^11
  function automatic int sine_point(input int idx, input int steps, input int frac);
    longint x, term, acc;
    x    = (HALF_PI_Q30 * longint'(idx)) / longint'(steps);
    term = x;
    acc  = x;
    for (int k = 1; k <= 5; k++) begin
      term = (term * x) >>> 30;
      term = (term * x) >>> 30;
      term = -term / longint'((2 * k) * (2 * k + 1));
      acc  = acc + term;
    end
    return int'((acc + (longint'(1) <<< (29 - frac))) >>> (30 - frac));
  endfunction

  // first angle code that belongs to sector index k
  function automatic longint sector_edge(input int k, input int ang_w);
    return ((longint'(k) <<< ang_w) + 11) / 12;
  endfunction

  // (2/sqrt(3)) * ts rounded to an integer
  function automatic longint period_gain(input int ts);
    return (longint'(ts) * INV_SIN60_Q20 + (longint'(1) <<< 19)) >>> 20;
  endfunction

endpackage

// File: rtl/dw_sector_ladder.sv
module dw_sector_ladder
  import lcm_dwell_pkg::*;
#(
  parameter int ANG_W    = 16,
  parameter int SUB_BITS = 6,
  parameter int IDX_W    = 8
) (
  input  logic [ANG_W-1:0] angle,
  output logic [3:0]       sector_idx,
  output logic             upper_half,
  output logic [IDX_W-1:0] idx_first,
  output logic [IDX_W-1:0] idx_second
);
  localparam int STEPS    = 1 << SUB_BITS;
  localparam int SCALED_W = ANG_W + 4;

  logic [SECTORS-2:0]    above;
  logic [SCALED_W-1:0]   scaled;
  logic [SCALED_W-1:0]   base;
  logic [SUB_BITS-1:0]   sub;
  sect_kind_e            kind;

  for (genvar k = 1; k < SECTORS; k++) begin : g_rung
    localparam logic [ANG_W-1:0] EDGE = ANG_W'(sector_edge(k, ANG_W));
    assign above[k-1] = (angle >= EDGE);
  end

  always_comb begin
    sector_idx = 4'd0;
    for (int i = 0; i < SECTORS - 1; i++) begin
      sector_idx = sector_idx + {3'd0, above[i]};
    end
  end

  assign scaled     = SCALED_W'(angle) * SCALED_W'(12);
  assign base       = SCALED_W'(sector_idx) << ANG_W;
  assign sub        = SUB_BITS'((scaled - base) >> (ANG_W - SUB_BITS));
  assign upper_half = sub[SUB_BITS-1];
  assign kind       = sector_idx[0] ? SECT_EVEN : SECT_ODD;

  // all sine arguments folded into 0..90 degrees, STEPS per 30 degrees
  always_comb begin
    if (kind == SECT_ODD) begin
      idx_first  = IDX_W'(2 * STEPS) + IDX_W'(sub);
      idx_second = IDX_W'(sub);
    end else begin
      idx_first  = IDX_W'(3 * STEPS) - IDX_W'(sub);
      idx_second = IDX_W'(STEPS) - IDX_W'(sub);
    end
  end
endmodule

// File: rtl/dw_sine_mul.sv
module dw_sine_mul
  import lcm_dwell_pkg::*;
#(
  parameter int MAG_W    = 16,
  parameter int SIN_FRAC = 15,
  parameter int SUB_BITS = 6,
  parameter int IDX_W    = 8,
  parameter int SIN_W    = SIN_FRAC + 1,
  parameter int PROD_W   = MAG_W + SIN_W
) (
  input  logic [MAG_W-1:0]            mag,
  input  logic [1:0][IDX_W-1:0]       idx,
  output logic [1:0][PROD_W-1:0]      prod
);
  localparam int STEPS   = 1 << SUB_BITS;
  localparam int ENTRIES = 3 * STEPS + 1;

  logic [SIN_W-1:0] tbl [ENTRIES];

  for (genvar i = 0; i < ENTRIES; i++) begin : g_tbl
    assign tbl[i] = SIN_W'(sine_point(i, 3 * STEPS, SIN_FRAC));
  end

  for (genvar c = 0; c < 2; c++) begin : g_ch
    assign prod[c] = PROD_W'(mag) * PROD_W'(tbl[idx[c]]);
  end
endmodule

// File: rtl/dw_time_scale.sv
module dw_time_scale #(
  parameter int     PROD_W = 32,
  parameter longint GAIN   = 11547,
  parameter int     GAIN_W = 14,
  parameter int     SHIFT  = 31,
  parameter int     TW     = 15
) (
  input  logic [PROD_W-1:0] prod,
  output logic [TW-1:0]     t
);
  localparam int MUL_W = PROD_W + GAIN_W;

  logic [MUL_W-1:0] full;

  assign full = MUL_W'(prod) * MUL_W'(GAIN);
  assign t    = TW'(full >> SHIFT);
endmodule

// File: rtl/dw_clamp.sv
module dw_clamp #(
  parameter int TS_CYCLES = 10000,
  parameter int CNT_W     = 14,
  parameter int TW        = CNT_W + 1
) (
  input  logic [TW-1:0]    ta,
  input  logic [TW-1:0]    tb,
  output logic [CNT_W-1:0] fa,
  output logic [CNT_W-1:0] fb,
  output logic [CNT_W-1:0] fz,
  output logic             over
);
  localparam int SUM_W = TW + 1;
  localparam int NUM_W = TW + CNT_W;
  localparam logic [CNT_W-1:0] TS_V = CNT_W'(TS_CYCLES);

  logic [SUM_W-1:0] sum;
  logic [NUM_W-1:0] num;
  logic [NUM_W-1:0] den;

  assign sum  = SUM_W'(ta) + SUM_W'(tb);
  assign over = (sum > SUM_W'(TS_CYCLES));
  assign num  = NUM_W'(ta) * NUM_W'(TS_V);
  assign den  = over ? NUM_W'(sum) : NUM_W'(1);

  always_comb begin
    if (over) begin
      fa = CNT_W'(num / den);
      fb = TS_V - fa;
      fz = '0;
    end else begin
      fa = CNT_W'(ta);
      fb = CNT_W'(tb);
      fz = TS_V - CNT_W'(sum);
    end
  end
endmodule

// File: rtl/twelve_sector_dwell.sv
module twelve_sector_dwell
  import lcm_dwell_pkg::*;
#(
  parameter int ANG_W     = 16,
  parameter int MAG_W     = 16,
  parameter int TS_CYCLES = 10000,
  parameter int SUB_BITS  = 6,
  parameter int SIN_FRAC  = 15,
  localparam int CNT_W    = $clog2(TS_CYCLES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [ANG_W-1:0] req_angle,
  input  logic [MAG_W-1:0] req_mag,
  output logic             out_valid,
  output logic [3:0]       out_sector,
  output logic             out_upper_half,
  output logic [CNT_W-1:0] out_t_first,
  output logic [CNT_W-1:0] out_t_second,
  output logic [CNT_W-1:0] out_t_zero
);
  localparam int     IDX_W  = $clog2(3 * (1 << SUB_BITS) + 1);
  localparam int     SIN_W  = SIN_FRAC + 1;
  localparam int     PROD_W = MAG_W + SIN_W;
  localparam longint GAIN   = period_gain(TS_CYCLES);
  localparam int     GAIN_W = $clog2(GAIN + 1);
  localparam int     TW     = CNT_W + 1;

  // stage 1: sector decode
  logic [3:0]            sec_c;
  logic                  half_c;
  logic [1:0][IDX_W-1:0] idx_c;
  logic                  v1;
  logic [3:0]            sec1;
  logic                  half1;
  logic [1:0][IDX_W-1:0] idx1;
  logic [MAG_W-1:0]      mag1;

  dw_sector_ladder #(.ANG_W(ANG_W), .SUB_BITS(SUB_BITS), .IDX_W(IDX_W)) u_ladder (
    .angle(req_angle), .sector_idx(sec_c), .upper_half(half_c),
    .idx_first(idx_c[0]), .idx_second(idx_c[1])
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v1 <= 1'b0; sec1 <= '0; half1 <= 1'b0; idx1 <= '0; mag1 <= '0;
    end else begin
      v1 <= req_valid;
      if (req_valid) begin
        sec1 <= sec_c; half1 <= half_c; idx1 <= idx_c; mag1 <= req_mag;
      end
    end
  end

  // stage 2: sine lookup times magnitude
  logic [1:0][PROD_W-1:0] prod_c;
  logic                   v2;
  logic [3:0]             sec2;
  logic                   half2;
  logic [1:0][PROD_W-1:0] prod2;

  dw_sine_mul #(.MAG_W(MAG_W), .SIN_FRAC(SIN_FRAC), .SUB_BITS(SUB_BITS),
                .IDX_W(IDX_W), .SIN_W(SIN_W), .PROD_W(PROD_W)) u_sine (
    .mag(mag1), .idx(idx1), .prod(prod_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v2 <= 1'b0; sec2 <= '0; half2 <= 1'b0; prod2 <= '0;
    end else begin
      v2 <= v1;
      if (v1) begin
        sec2 <= sec1; half2 <= half1; prod2 <= prod_c;
      end
    end
  end

  // stage 3: scale to period counts
  logic [1:0][TW-1:0] t_c;
  logic               v3;
  logic [3:0]         sec3;
  logic               half3;
  logic [1:0][TW-1:0] t3;

  for (genvar c = 0; c < 2; c++) begin : g_scale
    dw_time_scale #(.PROD_W(PROD_W), .GAIN(GAIN), .GAIN_W(GAIN_W),
                    .SHIFT(MAG_W + SIN_FRAC), .TW(TW)) u_scale (
      .prod(prod2[c]), .t(t_c[c])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      v3 <= 1'b0; sec3 <= '0; half3 <= 1'b0; t3 <= '0;
    end else begin
      v3 <= v2;
      if (v2) begin
        sec3 <= sec2; half3 <= half2; t3 <= t_c;
      end
    end
  end

  // stage 4: overflow clamp and zero time
  logic [CNT_W-1:0] fa_c, fb_c, fz_c;
  logic             over_c;
  logic             clamp_q;

  dw_clamp #(.TS_CYCLES(TS_CYCLES), .CNT_W(CNT_W), .TW(TW)) u_clamp (
    .ta(t3[0]), .tb(t3[1]), .fa(fa_c), .fb(fb_c), .fz(fz_c), .over(over_c)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0; out_sector <= '0; out_upper_half <= 1'b0;
      out_t_first <= '0; out_t_second <= '0; out_t_zero <= '0; clamp_q <= 1'b0;
    end else begin
      out_valid <= v3;
      if (v3) begin
        out_sector     <= sec3 + 4'd1;
        out_upper_half <= half3;
        out_t_first    <= fa_c;
        out_t_second   <= fb_c;
        out_t_zero     <= fz_c;
        clamp_q        <= over_c;
      end
    end
  end
endmodule

// File: rtl/dwell_checker.sv
module dwell_checker #(
  parameter int MAG_W     = 16,
  parameter int CNT_W     = 14,
  parameter int TS_CYCLES = 10000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic [MAG_W-1:0] req_mag,
  input logic             out_valid,
  input logic [3:0]       out_sector,
  input logic [CNT_W-1:0] out_t_first,
  input logic [CNT_W-1:0] out_t_second,
  input logic [CNT_W-1:0] out_t_zero,
  input logic             clamp_q
);
  a_r1_sector_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_sector >= 4'd1 && out_sector <= 4'd12));

  a_r5_period_sum: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((CNT_W+2)'(out_t_first) + (CNT_W+2)'(out_t_second)
                   + (CNT_W+2)'(out_t_zero) == (CNT_W+2)'(TS_CYCLES)));

  a_r6_clamp_no_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && clamp_q) |-> (out_t_zero == '0));

  a_r7_latency: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid == $past(req_valid, 4));

  a_r8_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> ($stable(out_sector) && $stable(out_t_first)
                    && $stable(out_t_second) && $stable(out_t_zero)));

  a_r10_zero_mag: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(req_valid, 4) && $past(req_mag, 4) == '0) |->
      (out_t_first == '0 && out_t_second == '0));
endmodule

bind twelve_sector_dwell dwell_checker #(
  .MAG_W(MAG_W), .CNT_W(CNT_W), .TS_CYCLES(TS_CYCLES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_mag(req_mag),
  .out_valid(out_valid), .out_sector(out_sector), .out_t_first(out_t_first),
  .out_t_second(out_t_second), .out_t_zero(out_t_zero), .clamp_q(clamp_q)
);

// File: tb/sim_twelve_sector_dwell.sv
`timescale 1ns/1ps
module sim_twelve_sector_dwell;
  localparam int ANG_W = 16;
  localparam int MAG_W = 16;
  localparam int TS    = 10000;
  localparam int CNT_W = $clog2(TS + 1);
  localparam longint FULL = longint'(1) << ANG_W;
  localparam real TOL  = TS / 50.0;
  localparam real PI   = 3.14159265358979;

  typedef struct {
    int     sector;
    bit     half;
    real    ta;
    real    tb;
    real    tz;
    longint issue;
    string  tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0;
  logic [ANG_W-1:0] req_angle = '0;
  logic [MAG_W-1:0] req_mag = '0;
  logic out_valid;
  logic [3:0] out_sector;
  logic out_upper_half;
  logic [CNT_W-1:0] out_t_first, out_t_second, out_t_zero;

  int checks = 0;
  int errors = 0;
  longint cyc = 0;
  exp_t sb[$];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  twelve_sector_dwell #(.ANG_W(ANG_W), .MAG_W(MAG_W), .TS_CYCLES(TS)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_angle(req_angle),
    .req_mag(req_mag), .out_valid(out_valid), .out_sector(out_sector),
    .out_upper_half(out_upper_half), .out_t_first(out_t_first),
    .out_t_second(out_t_second), .out_t_zero(out_t_zero)
  );

  task automatic chk_int(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  task automatic chk_near(input string req, input string what, input longint act, input real expv);
    real d;
    checks++;
    d = real'(act) - expv;
    if (d < 0.0) d = -d;
    if (d > TOL) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %f", req, what, act, expv);
    end
  endtask

  // expected result from the requirement formulas, in real arithmetic
  function automatic exp_t model(input longint a, input longint m);
    exp_t e;
    longint r;
    real th, c, p, q, s;
    r        = (a * 12) % FULL;
    e.sector = int'((a * 12) / FULL) + 1;
    e.half   = (r >= FULL / 2);
    th       = real'(r) * 30.0 / real'(FULL);
    c        = 2.0 / $sqrt(3.0) * (real'(m) / 65536.0) * TS;
    if (e.sector % 2 == 1) begin
      p = c * $sin((120.0 - th) * PI / 180.0);
      q = c * $sin(th * PI / 180.0);
      e.tag = "R3";
    end else begin
      p = c * $sin((th + 90.0) * PI / 180.0);
      q = c * $sin((30.0 - th) * PI / 180.0);
      e.tag = "R4";
    end
    if (m == 0) e.tag = "R10";
    s = p + q;
    if (s > TS) begin
      p = p * TS / s;
      q = TS - p;
      e.tz = 0.0;
      e.tag = "R6";
    end else begin
      e.tz = TS - s;
    end
    e.ta = p;
    e.tb = q;
    return e;
  endfunction

  task automatic send(input longint a, input longint m);
    exp_t e;
    @(negedge clk);
    e = model(a, m);
    e.issue = cyc;
    sb.push_back(e);
    req_valid = 1'b1;
    req_angle = ANG_W'(a);
    req_mag   = MAG_W'(m);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
    end
  endtask

  // monitor: pops the scoreboard on each result strobe
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R7 unexpected result: actual valid expected none");
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk_int("R7", "latency", cyc - e.issue, 4);
        chk_int("R1", "sector", out_sector, e.sector);
        chk_int("R2", "upper half", out_upper_half, e.half);
        chk_near(e.tag, "first time", out_t_first, e.ta);
        chk_near(e.tag, "second time", out_t_second, e.tb);
        chk_near(e.tag, "zero time", out_t_zero, e.tz);
        chk_int("R5", "period sum", out_t_first + out_t_second + out_t_zero, TS);
        if (e.tag == "R10") begin
          chk_int("R10", "zero mag first", out_t_first, 0);
          chk_int("R10", "zero mag zero time", out_t_zero, TS);
        end
        if (e.tag == "R6") chk_int("R6", "clamped zero time", out_t_zero, 0);
      end
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R7 watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    logic [3:0] h_sec;
    logic [CNT_W-1:0] h_a, h_b, h_z;
    repeat (5) @(negedge clk);
    // R9: reset state
    chk_int("R9", "valid in reset", out_valid, 0);
    chk_int("R9", "sector in reset", out_sector, 0);
    chk_int("R9", "half in reset", out_upper_half, 0);
    chk_int("R9", "times in reset", out_t_first + out_t_second + out_t_zero, 0);
    rst_n = 1'b1;
    idle(3);

    // R3 R4: both halves of every sector, spaced requests
    for (int k = 0; k < 12; k++) begin
      send((longint'(k) * FULL) / 12 + 1000, 32768);
      idle(2);
      send((longint'(k) * FULL) / 12 + 4400, 30000);
      idle(1);
    end
    idle(6);

    // R1: sector edges; R2: the 15 degree split
    for (int k = 1; k < 12; k++) begin
      longint e0, h0;
      e0 = (longint'(k) * FULL + 11) / 12;
      h0 = ((2 * longint'(k) + 1) * FULL + 23) / 24;
      send(e0, 20000);
      send(e0 - 1, 20000);
      send(h0, 20000);
      send(h0 - 1, 20000);
    end
    send(0, 20000);
    send(FULL - 1, 20000);
    idle(6);

    // R10: zero magnitude; R6: overflow clamp in odd and even sectors
    send(12345, 0);
    send(40000, 0);
    send(5000, 57344);
    send(8000, 57344);
    send(30000, 65535);
    send(60000, 61000);
    send(0, 65535);
    idle(8);

    // R8: outputs hold while request inputs move without a strobe
    h_sec = out_sector; h_a = out_t_first; h_b = out_t_second; h_z = out_t_zero;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      req_angle = ANG_W'(i * 7919);
      req_mag   = MAG_W'(i * 3001);
    end
    chk_int("R8", "held sector", out_sector, h_sec);
    chk_int("R8", "held first", out_t_first, h_a);
    chk_int("R8", "held second", out_t_second, h_b);
    chk_int("R8", "held zero", out_t_zero, h_z);
    chk_int("R7", "pending results", sb.size(), 0);
    finish_run();
  end
endmodule